// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sits next to a simple in-order CPU core and decides, every cycle, whether a synchronous exception, a non-maskable interrupt or an ordinary interrupt is taken. When one is taken, the block computes the return address, saves the status register, raises the block and privileged bits, and redirects fetch to a handler. It also carries out the return-from-exception instruction: it restores the status register, branches back to the saved address, and then judges the one instruction in that return's delay slot under the correct status register.

The pipeline supplies the current, next and branch-target PCs, together with flags that mark an instruction as sitting in a delay slot or as a delayed branch. Exception requests carry a type (re-execution or completion), a cause code, a user-break flag and an instruction-fetch flag. A status-register write port lets software clear the block bit. An exception that arrives while the block bit is set turns into a manual reset. An interrupt that arrives in that state waits, unless the core is in a low-power state or, for the non-maskable interrupt, a policy input allows it.

Top module: `exc_ctrl`

## Requirements
- R1: After reset, status register = 0x700000F0 (privileged bit 30 = 1, block bit 28 = 1), saved PC = saved SR = event code = 0, and redirect_valid and mreset_req are low.
- R2: For a re-execution exception (exc_completion = 0), saved PC = cur_pc. If in_slot = 1, saved PC = cur_pc − 2, which is the delayed branch, whatever that branch's condition.
- R3: For a completion exception (exc_completion = 1), saved PC = next_pc, or br_target when is_dbranch = 1. For an interrupt, saved PC = next_pc.
- R4: A taken event updates the outputs on the next cycle. Saved SR = old SR. SR = old SR with bits 30 and 28 set. redirect_pc = 0x80000100 for an exception or 0x80000600 for an interrupt, with redirect_valid pulsed for one cycle. For exceptions only, event_code = the 12-bit cause zero-extended.
- R5: An exception other than a user break that arrives while the block bit is 1 pulses mreset_req and loads event_code = 0x00000020, redirect_pc = 0xA0000000 and SR = 0x700000F0. A user break in the same state is discarded and leaves SR unchanged.
- R6: An ordinary interrupt that arrives while the block bit is 1 causes no redirect. It is taken the cycle after software writes SR with the block bit cleared, provided the request is still held.
- R7: A non-maskable interrupt that arrives while the block bit is 1 is taken when nmi_unblock = 1 and waits when nmi_unblock = 0.
- R8: When low_power = 1, both kinds of interrupt are taken regardless of the block bit.
- R9: A return strobe with no competing request loads SR from saved SR and redirects to saved PC on the next cycle.
- R10: In the cycle after a return strobe, an exception with exc_ifetch = 1 is judged by the block bit from before the restore. Any other exception is judged by the restored SR.
- R11: When several requests arrive together, the order is: reset-causing exception, then other exception, then non-maskable interrupt, then ordinary interrupt. Interrupts are not taken on a return strobe cycle.
- R12: sr_we loads sr_wdata into SR when no event and no return strobe occur in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| cur_pc | input | 32 | PC of the instruction in the execute stage |
| next_pc | input | 32 | PC of the following instruction |
| br_target | input | 32 | Destination of the delayed branch |
| in_slot | input | 1 | Current instruction sits in a delay slot |
| is_dbranch | input | 1 | Current instruction is a branch with a delay slot |
| exc_req | input | 1 | Synchronous exception request |
| exc_completion | input | 1 | 1 = completion type, 0 = re-execution type |
| exc_ubreak | input | 1 | Exception is a user break |
| exc_ifetch | input | 1 | Exception stems from instruction access |
| exc_cause | input | 12 | Cause code for the event register |
| irq_req | input | 1 | Ordinary interrupt request (level) |
| nmi_req | input | 1 | Non-maskable interrupt request (level) |
| nmi_unblock | input | 1 | Accept the non-maskable interrupt even when the block bit is set |
| low_power | input | 1 | Core is in sleep or standby |
| rte_strobe | input | 1 | Return-from-exception executes this cycle |
| sr_we | input | 1 | Software write of SR |
| sr_wdata | input | 32 | Data for SR write |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | Fetch redirect address |
| sr_o | output | 32 | Status register |
| spc_o | output | 32 | Saved PC |
| ssr_o | output | 32 | Saved status register |
| event_code | output | 32 | Exception event register |
| mreset_req | output | 1 | Manual reset request pulse |

## Verification
On every cycle, the assertions check that a clean return strobe restores SR from the saved SR and jumps to the saved PC. They also check that every entry leaves the block and privileged bits set and copies the old SR, that a manual reset only follows a set block bit and always carries code 0x20 and the reset address, and that a blocked interrupt never redirects. The bench scenarios cover the rest. These include the saved-PC choice across delay-slot and branch positions, the interrupt that waits until software clears the block bit, the non-maskable interrupt policy and low-power bypass, and the old-versus-new status judgement in the return's delay slot.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int XLEN     = 32;
    localparam int CAUSE_W  = 12;
    localparam int BL_BIT   = 28;
    localparam int MD_BIT   = 30;
    localparam logic [XLEN-1:0] MRESET_CODE = 32'h0000_0020;

    typedef struct packed {
        logic [XLEN-1:0] sr;
        logic [XLEN-1:0] spc;
        logic [XLEN-1:0] ssr;
        logic [XLEN-1:0] evt;
        logic [XLEN-1:0] rpc;
        logic            rvalid;
        logic            mreset;
        logic            slot_rte;
        logic            old_bl;
    } ctl_state_t;
endpackage

// File: rtl/exc_accept.sv
module exc_accept (
    input  logic exc_req,
    input  logic exc_ubreak,
    input  logic exc_ifetch,
    input  logic in_rte_slot,
    input  logic bl_now,
    input  logic bl_before,
    input  logic irq_req,
    input  logic nmi_req,
    input  logic nmi_unblock,
    input  logic low_power,
    input  logic rte_strobe,
    output logic take_reset,
    output logic take_exc,
    output logic take_nmi,
    output logic take_irq
);
    logic bl_judge;
    logic nmi_ok;
    logic irq_ok;

    always_comb begin
        // fetch-side faults in the return's slot see the pre-restore SR
        bl_judge   = (in_rte_slot && exc_ifetch) ? bl_before : bl_now;
        take_reset = exc_req && bl_judge && !exc_ubreak;
        take_exc   = exc_req && !bl_judge;
        nmi_ok     = nmi_req && !rte_strobe && (!bl_now || nmi_unblock || low_power);
        irq_ok     = irq_req && !rte_strobe && (!bl_now || low_power);
        take_nmi   = !exc_req && nmi_ok;
        take_irq   = !exc_req && !nmi_ok && irq_ok;
    end
endmodule

// File: rtl/exc_retpc.sv
module exc_retpc #(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 2
) (
    input  logic            is_async,
    input  logic            completion,
    input  logic            in_slot,
    input  logic            is_dbranch,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] next_pc,
    input  logic [XLEN-1:0] br_target,
    output logic [XLEN-1:0] ret_pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    always_comb begin
        if (is_async)
            ret_pc = next_pc;
        else if (completion)
            ret_pc = is_dbranch ? br_target : next_pc;
        else
            ret_pc = in_slot ? (cur_pc - STEP) : cur_pc;
    end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl #(
    parameter int               XLEN        = 32,
    parameter int               CAUSE_W     = 12,
    parameter int               INSN_BYTES  = 2,
    parameter logic [XLEN-1:0]  HANDLER_BASE = 32'h8000_0000,
    parameter logic [XLEN-1:0]  EXC_OFS     = 32'h0000_0100,
    parameter logic [XLEN-1:0]  IRQ_OFS     = 32'h0000_0600,
    parameter logic [XLEN-1:0]  RESET_VEC   = 32'hA000_0000,
    parameter logic [XLEN-1:0]  RESET_SR    = 32'h7000_00F0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic [XLEN-1:0]    next_pc,
    input  logic [XLEN-1:0]    br_target,
    input  logic               in_slot,
    input  logic               is_dbranch,
    input  logic               exc_req,
    input  logic               exc_completion,
    input  logic               exc_ubreak,
    input  logic               exc_ifetch,
    input  logic [CAUSE_W-1:0] exc_cause,
    input  logic               irq_req,
    input  logic               nmi_req,
    input  logic               nmi_unblock,
    input  logic               low_power,
    input  logic               rte_strobe,
    input  logic               sr_we,
    input  logic [XLEN-1:0]    sr_wdata,
    output logic               redirect_valid,
    output logic [XLEN-1:0]    redirect_pc,
    output logic [XLEN-1:0]    sr_o,
    output logic [XLEN-1:0]    spc_o,
    output logic [XLEN-1:0]    ssr_o,
    output logic [XLEN-1:0]    event_code,
    output logic               mreset_req
);
    import exc_pkg::*;

    localparam logic [XLEN-1:0] ENTRY_SET = (XLEN'(1) << BL_BIT) | (XLEN'(1) << MD_BIT);

    ctl_state_t st_d, st_q;
    logic take_reset, take_exc, take_nmi, take_irq;
    logic [XLEN-1:0] ret_pc;

    exc_accept u_accept (
        .exc_req     (exc_req),
        .exc_ubreak  (exc_ubreak),
        .exc_ifetch  (exc_ifetch),
        .in_rte_slot (st_q.slot_rte),
        .bl_now      (st_q.sr[BL_BIT]),
        .bl_before   (st_q.old_bl),
        .irq_req     (irq_req),
        .nmi_req     (nmi_req),
        .nmi_unblock (nmi_unblock),
        .low_power   (low_power),
        .rte_strobe  (rte_strobe),
        .take_reset  (take_reset),
        .take_exc    (take_exc),
        .take_nmi    (take_nmi),
        .take_irq    (take_irq)
    );

    exc_retpc #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_retpc (
        .is_async   (!exc_req),
        .completion (exc_completion),
        .in_slot    (in_slot),
        .is_dbranch (is_dbranch),
        .cur_pc     (cur_pc),
        .next_pc    (next_pc),
        .br_target  (br_target),
        .ret_pc     (ret_pc)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rvalid   = 1'b0;
        st_d.mreset   = 1'b0;
        st_d.slot_rte = 1'b0;
        if (take_reset) begin
            st_d.sr     = RESET_SR;
            st_d.rpc    = RESET_VEC;
            st_d.rvalid = 1'b1;
            st_d.evt    = MRESET_CODE;
            st_d.mreset = 1'b1;
        end else if (take_exc || take_nmi || take_irq) begin
            st_d.ssr    = st_q.sr;
            st_d.spc    = ret_pc;
            st_d.sr     = st_q.sr | ENTRY_SET;
            st_d.rvalid = 1'b1;
            st_d.rpc    = HANDLER_BASE + (take_exc ? EXC_OFS : IRQ_OFS);
            if (take_exc)
                st_d.evt = XLEN'(exc_cause);
        end else if (rte_strobe) begin
            st_d.sr       = st_q.ssr;
            st_d.rpc      = st_q.spc;
            st_d.rvalid   = 1'b1;
            st_d.slot_rte = 1'b1;
            st_d.old_bl   = st_q.sr[BL_BIT];
        end else if (sr_we) begin
            st_d.sr = sr_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.sr       <= RESET_SR;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_valid = st_q.rvalid;
    assign redirect_pc    = st_q.rpc;
    assign sr_o           = st_q.sr;
    assign spc_o          = st_q.spc;
    assign ssr_o          = st_q.ssr;
    assign event_code     = st_q.evt;
    assign mreset_req     = st_q.mreset;
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
    parameter int              XLEN      = 32,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hA000_0000
) (
    input logic            clk,
    input logic            rst_n,
    input logic            exc_req,
    input logic            irq_req,
    input logic            nmi_req,
    input logic            low_power,
    input logic            rte_strobe,
    input logic            redirect_valid,
    input logic [XLEN-1:0] redirect_pc,
    input logic [XLEN-1:0] sr_o,
    input logic [XLEN-1:0] spc_o,
    input logic [XLEN-1:0] ssr_o,
    input logic [XLEN-1:0] event_code,
    input logic            mreset_req
);
    import exc_pkg::*;

    // R9: clean return restores SR and jumps to saved PC
    a_r9_rte_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_strobe && !exc_req && !irq_req && !nmi_req) |=>
            (redirect_valid && redirect_pc == $past(spc_o) && sr_o == $past(ssr_o)));

    // R4: any entry leaves block and privileged bits set
    a_r4_entry_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !$past(rte_strobe)) |-> (sr_o[BL_BIT] && sr_o[MD_BIT]));

    // R4: ordinary entry copies the previous SR
    a_r4_ssr_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && !mreset_req && !$past(rte_strobe)) |-> (ssr_o == $past(sr_o)));

    // R5: manual reset carries its code and address
    a_r5_mreset_code: assert property (@(posedge clk) disable iff (!rst_n)
        mreset_req |-> (event_code == 32'h20 && redirect_pc == RESET_VEC));

    // R5: manual reset only when a block bit governed the decision
    a_r5_mreset_needs_bl: assert property (@(posedge clk) disable iff (!rst_n)
        mreset_req |-> ($past(sr_o[BL_BIT]) || $past(sr_o[BL_BIT], 2)));

    // R6: blocked ordinary interrupt never redirects
    a_r6_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && sr_o[BL_BIT] && !low_power && !exc_req && !nmi_req && !rte_strobe)
            |=> !redirect_valid);
endmodule

bind exc_ctrl exc_ctrl_chk #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .exc_req        (exc_req),
    .irq_req        (irq_req),
    .nmi_req        (nmi_req),
    .low_power      (low_power),
    .rte_strobe     (rte_strobe),
    .redirect_valid (redirect_valid),
    .redirect_pc    (redirect_pc),
    .sr_o           (sr_o),
    .spc_o          (spc_o),
    .ssr_o          (ssr_o),
    .event_code     (event_code),
    .mreset_req     (mreset_req)
);

// File: tb/test_exc_ctrl.sv
`timescale 1ns/1ps
module test_exc_ctrl;
    localparam logic [31:0] S0 = 32'h4000_0000;
    localparam logic [31:0] SB = 32'h5000_0000;
    localparam logic [31:0] HE = 32'h8000_0100;
    localparam logic [31:0] HI = 32'h8000_0600;
    localparam logic [31:0] RV = 32'hA000_0000;
    localparam logic [31:0] RSR = 32'h7000_00F0;

    logic clk = 0, rst_n = 0;
    logic [31:0] cur_pc = 32'h1000, next_pc = 32'h1002, br_target = 32'h2000;
    logic in_slot = 0, is_dbranch = 0, exc_req = 0, exc_completion = 0;
    logic exc_ubreak = 0, exc_ifetch = 0, irq_req = 0, nmi_req = 0;
    logic nmi_unblock = 0, low_power = 0, rte_strobe = 0, sr_we = 0;
    logic [11:0] exc_cause = 12'h0E0;
    logic [31:0] sr_wdata = '0;
    logic redirect_valid, mreset_req;
    logic [31:0] redirect_pc, sr_o, spc_o, ssr_o, event_code;
    int total = 0, bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    exc_ctrl i_exc_ctrl (.*);

    typedef struct packed {
        logic [3:0]  req;
        logic [31:0] sr;
        logic exc, cmpl, slot, dbr, ubrk, irq, nmi, nmiu, lp;
        logic        rv;
        logic [31:0] rpc;
        logic [31:0] spc;
        logic        mr;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{4'd2,  S0, 1,0,0,0,0,0,0,0,0, 1, HE, 32'h1000, 0}, // R2 plain
        '{4'd2,  S0, 1,0,1,0,0,0,0,0,0, 1, HE, 32'h0FFE, 0}, // R2 delay slot
        '{4'd3,  S0, 1,1,0,0,0,0,0,0,0, 1, HE, 32'h1002, 0}, // R3 plain
        '{4'd3,  S0, 1,1,0,1,0,0,0,0,0, 1, HE, 32'h2000, 0}, // R3 delayed branch
        '{4'd4,  S0, 0,0,0,0,0,1,0,0,0, 1, HI, 32'h1002, 0}, // R4 interrupt entry
        '{4'd6,  SB, 0,0,0,0,0,1,0,0,0, 0, 0,  0,        0}, // R6 blocked
        '{4'd8,  SB, 0,0,0,0,0,1,0,0,1, 1, HI, 32'h1002, 0}, // R8 low power irq
        '{4'd7,  SB, 0,0,0,0,0,0,1,0,0, 0, 0,  0,        0}, // R7 nmi waits
        '{4'd7,  SB, 0,0,0,0,0,0,1,1,0, 1, HI, 32'h1002, 0}, // R7 nmi allowed
        '{4'd5,  SB, 1,0,0,0,0,0,0,0,0, 1, RV, 0,        1}, // R5 manual reset
        '{4'd5,  SB, 1,0,0,0,1,0,0,0,0, 0, 0,  0,        0}, // R5 user break dropped
        '{4'd11, S0, 1,0,0,0,0,1,1,0,0, 1, HE, 32'h1000, 0}, // R11 exception first
        '{4'd8,  SB, 0,0,0,0,0,0,1,0,1, 1, HI, 32'h1002, 0}, // R8 low power nmi
        '{4'd3,  S0, 0,0,0,1,0,1,0,0,0, 1, HI, 32'h1002, 0}  // R3 irq ignores branch
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        exc_req = 0; exc_completion = 0; in_slot = 0; is_dbranch = 0;
        exc_ubreak = 0; exc_ifetch = 0; irq_req = 0; nmi_req = 0;
        nmi_unblock = 0; low_power = 0; rte_strobe = 0; sr_we = 0;
        exc_cause = 12'h0E0;
    endtask

    task automatic write_sr(input logic [31:0] v);
        sr_we = 1; sr_wdata = v;
        step();
        sr_we = 0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 sr", sr_o, RSR);
        chk("R1 spc", spc_o, 0);
        chk("R1 ssr", ssr_o, 0);
        chk("R1 evt", event_code, 0);
        chk("R1 rv", {31'd0, redirect_valid}, 0);
        chk("R1 mr", {31'd0, mreset_req}, 0);
        rst_n = 1;
        step();

        for (int i = 0; i < NV; i++) begin
            string t;
            logic [31:0] exp_sr;
            t = $sformatf("R%0d vec%0d", VEC[i].req, i);
            write_sr(VEC[i].sr);
            exc_req = VEC[i].exc; exc_completion = VEC[i].cmpl; in_slot = VEC[i].slot;
            is_dbranch = VEC[i].dbr; exc_ubreak = VEC[i].ubrk; irq_req = VEC[i].irq;
            nmi_req = VEC[i].nmi; nmi_unblock = VEC[i].nmiu; low_power = VEC[i].lp;
            step();
            clear_in();
            exp_sr = VEC[i].mr ? RSR : (VEC[i].rv ? (VEC[i].sr | SB) : VEC[i].sr);
            chk({t, " rv"}, {31'd0, redirect_valid}, {31'd0, VEC[i].rv});
            chk({t, " mr"}, {31'd0, mreset_req}, {31'd0, VEC[i].mr});
            chk({t, " sr"}, sr_o, exp_sr);
            if (VEC[i].rv) chk({t, " pc"}, redirect_pc, VEC[i].rpc);
            if (VEC[i].rv && !VEC[i].mr) begin
                chk({t, " spc"}, spc_o, VEC[i].spc);
                chk({t, " ssr"}, ssr_o, VEC[i].sr);
            end
            if (VEC[i].mr) chk({t, " evt"}, event_code, 32'h20);
            else if (VEC[i].rv && VEC[i].exc) chk({t, " evt"}, event_code, 32'h0E0);
            step();
        end

        // R6 and R12: interrupt waits until software clears the block bit
        write_sr(SB);
        irq_req = 1;
        step(); chk("R6 wait1", {31'd0, redirect_valid}, 0);
        step(); chk("R6 wait2", {31'd0, redirect_valid}, 0);
        sr_we = 1; sr_wdata = S0;
        step(); sr_we = 0;
        chk("R12 sr write", sr_o, S0);
        chk("R6 wait3", {31'd0, redirect_valid}, 0);
        step();
        chk("R6 taken", {31'd0, redirect_valid}, 1);
        chk("R6 pc", redirect_pc, HI);
        irq_req = 0;
        step();

        // R9 and R10: return, then fetch fault in the slot sees old block bit
        write_sr(S0);
        exc_req = 1; exc_cause = 12'h0C0;
        step(); clear_in();
        chk("R4 evt cause", event_code, 32'h0C0);
        chk("R4 ssr", ssr_o, S0);
        rte_strobe = 1;
        step(); rte_strobe = 0;
        chk("R9 rv", {31'd0, redirect_valid}, 1);
        chk("R9 pc", redirect_pc, 32'h1000);
        chk("R9 sr", sr_o, S0);
        exc_req = 1; exc_ifetch = 1;
        step(); clear_in();
        chk("R10 ifetch old SR", {31'd0, mreset_req}, 1);
        chk("R10 ifetch pc", redirect_pc, RV);
        step();

        // R10: non-fetch fault in the slot judged by restored SR
        write_sr(S0);
        exc_req = 1;
        step(); clear_in();
        rte_strobe = 1;
        step(); rte_strobe = 0;
        exc_req = 1; exc_cause = 12'h1E0;
        step(); clear_in();
        chk("R10 other mr", {31'd0, mreset_req}, 0);
        chk("R10 other pc", redirect_pc, HE);
        chk("R10 other evt", event_code, 32'h1E0);
        chk("R10 other ssr", ssr_o, S0);
        step();

        // R11: no interrupt on a return strobe cycle
        write_sr(S0);
        exc_req = 1;
        step(); clear_in();
        rte_strobe = 1; irq_req = 1; nmi_req = 1; low_power = 1;
        step(); clear_in();
        chk("R11 rte wins pc", redirect_pc, 32'h1000);
        chk("R11 rte wins sr", sr_o, S0);

        done = 1;
        finish_run();
    end
endmodule